// File: doc/BRIEF.md
# Nine-Bit SPI Word Serializer

This block sends command and parameter bytes for a display controller over a write-only serial link. Each byte arrives on a valid/ready stream with a flag that marks it as a command or as data. On the wire every byte becomes a 9-bit word: the flag goes first, then the eight payload bits. A per-byte end marker closes the transaction. Chip select stays low from the first bit of a transaction to its last bit.

There are two output modes. In native mode each accepted word is shifted straight out as nine clock pulses. In emulation mode the block collects up to eight words into one packed buffer and shifts it as whole 8-bit bytes. This serves a host that can only move bytes: eight words fill exactly nine bytes. A short final group is padded with zeros up to the next byte boundary. Emulation is used when the native capability parameter is off, or when the force input is high. The mode is fixed at the start of each transaction.

Top module: `nine_bit_spi_tx`

## Requirements
- R1: After reset, csN is 1, sclk is 0, mosi is 0 and inReady is 1.
- R2: A word is sent as the inDc flag (0 = command, 1 = parameter or pixel data) followed by inData bit 7 down to bit 0. One bit is sent per sclk period.
- R3: sclk idles low. mosi changes only while sclk is low and holds its value across each sclk rising edge (SPI mode 0). sclk never pulses while csN is high.
- R4: In native mode each accepted word produces exactly 9 sclk rising edges and no padding bits.
- R5: In emulation mode, inReady stays high while fewer than 8 words of the current group have been taken. A full group of 8 words is sent as 72 back-to-back bits, 9 bytes, with no bits between words.
- R6: In emulation mode, when a transaction ends with a partial group, the bits of that group are followed by zero bits up to the next multiple of 8 before csN rises.
- R7: csN falls when the first bit of a transaction is presented. It stays low between words and groups. It rises only after the falling sclk edge that ends the last bit of a word accepted with inLast = 1.
- R8: Emulation mode is used when forceEmu is 1 or the parameter NATIVE_OK is 0. The mode is sampled when the first word of a transaction is accepted, and it is held until csN rises.
- R9: inReady is 0 for the whole time a word or packed group is being shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| forceEmu | input | 1 | Forces byte-packed emulation mode |
| inValid | input | 1 | Input byte is valid |
| inReady | output | 1 | Block can accept a byte |
| inData | input | 8 | Payload byte |
| inDc | input | 1 | Flag: 0 command, 1 data |
| inLast | input | 1 | Byte ends the transaction |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| csN | output | 1 | Active-low chip select |

## Verification
The embedded assertions check several properties on every cycle. sclk stays quiet while chip select is high, and inReady stays low while sclk is high. mosi holds steady across each rising sclk edge. Chip select rises only at the end of a bit of a transaction's final word. Every shift length is 9 bits in native mode and a multiple of 8 bits in emulation mode. The other behaviours only show up in the bench's scenarios: the exact bit order on the wire, the zero padding of short groups, the packing of full groups, and the latching of the mode when forceEmu changes partway through a transaction.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
  typedef struct packed {
    logic load;
    logic start;
    logic shift;
    logic clear;
    logic emu;
  } dpCtl_t;
endpackage

// File: rtl/spi9_datapath.sv
module spi9_datapath
  import spi9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GROUP  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic              inDc,
  output logic [$clog2(GROUP+1)-1:0] wordCnt,
  output logic              lastBit,
  output logic              mosi
);
  localparam int WORD_W = DATA_W + 1;
  localparam int BUF_W  = WORD_W * GROUP;
  localparam int GC_W   = $clog2(GROUP + 1);
  localparam int CNT_W  = $clog2(BUF_W + DATA_W + 1);
  localparam logic [CNT_W-1:0] PAD_MASK = CNT_W'(DATA_W - 1);

  logic [BUF_W-1:0] shiftBuf;
  logic [CNT_W-1:0] bitsLeft;
  logic [GC_W-1:0]  nextCnt;
  logic [CNT_W-1:0] bitsRaw;
  logic [CNT_W-1:0] bitsPadded;

  always_comb begin
    nextCnt    = wordCnt + GC_W'(ctl.load);
    bitsRaw    = CNT_W'(nextCnt) * CNT_W'(WORD_W);
    bitsPadded = (bitsRaw + PAD_MASK) & ~PAD_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftBuf <= '0;
      wordCnt  <= '0;
      bitsLeft <= '0;
    end else begin
      if (ctl.clear) begin
        shiftBuf <= '0;
        wordCnt  <= '0;
        bitsLeft <= '0;
      end else begin
        if (ctl.load) begin
          for (int k = 0; k < GROUP; k++) begin
            if (wordCnt == GC_W'(k))
              shiftBuf[BUF_W-1-WORD_W*k -: WORD_W] <= {inDc, inData};
          end
          wordCnt <= nextCnt;
        end else if (ctl.shift) begin
          shiftBuf <= {shiftBuf[BUF_W-2:0], 1'b0};
        end
        if (ctl.start)
          bitsLeft <= ctl.emu ? bitsPadded : CNT_W'(WORD_W);
        else if (ctl.shift)
          bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end

  assign lastBit = (bitsLeft == CNT_W'(1));
  assign mosi    = shiftBuf[BUF_W-1];

  // R5
  group_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= GC_W'(GROUP));
  // R4
  native_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.start && !ctl.emu) |=> bitsLeft == CNT_W'(WORD_W));
  // R6
  pad_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.start && ctl.emu) |=> ((bitsLeft & PAD_MASK) == '0 && bitsLeft != '0));
endmodule

// File: rtl/spi9_control.sv
module spi9_control
  import spi9_pkg::*;
#(
  parameter int GROUP     = 8,
  parameter int HALF_DIV  = 2,
  parameter bit NATIVE_OK = 1'b1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   forceEmu,
  input  logic   inValid,
  input  logic   inLast,
  input  logic [$clog2(GROUP+1)-1:0] wordCnt,
  input  logic   lastBit,
  output logic   inReady,
  output logic   sclk,
  output logic   csN,
  output dpCtl_t ctl
);
  localparam int GC_W  = $clog2(GROUP + 1);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  typedef enum logic {ST_ACCEPT, ST_SHIFT} state_t;

  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic             phase;
  logic             lastSeen;
  logic             emuMode;
  logic             modeReq;
  logic             newTxn;
  logic             emuNow;
  logic             accept;
  logic             tick;

  always_comb begin
    modeReq   = forceEmu | !NATIVE_OK;
    newTxn    = csN && (wordCnt == '0);
    emuNow    = newTxn ? modeReq : emuMode;
    inReady   = (state == ST_ACCEPT);
    accept    = inValid && inReady;
    tick      = (divCnt == DIV_W'(HALF_DIV - 1));
    ctl.emu   = emuNow;
    ctl.load  = accept;
    ctl.start = accept && (!emuNow || inLast || wordCnt == GC_W'(GROUP - 1));
    ctl.shift = (state == ST_SHIFT) && tick && phase;
    ctl.clear = ctl.shift && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_ACCEPT;
      divCnt   <= '0;
      phase    <= 1'b0;
      csN      <= 1'b1;
      lastSeen <= 1'b0;
      emuMode  <= 1'b0;
    end else begin
      if (accept && newTxn) emuMode <= modeReq;
      if (accept) lastSeen <= inLast;
      if (ctl.start) begin
        state  <= ST_SHIFT;
        csN    <= 1'b0;
        divCnt <= '0;
        phase  <= 1'b0;
      end else if (state == ST_SHIFT) begin
        if (tick) begin
          divCnt <= '0;
          phase  <= ~phase;
          if (phase && lastBit) begin
            state <= ST_ACCEPT;
            if (lastSeen) csN <= 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign sclk = (state == ST_SHIFT) && phase;

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !inReady);
  // R7
  cs_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> ($past(sclk) && $past(lastSeen)));
endmodule

// File: rtl/nine_bit_spi_tx.sv
module nine_bit_spi_tx
  import spi9_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int GROUP     = 8,
  parameter int HALF_DIV  = 2,
  parameter bit NATIVE_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              forceEmu,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inDc,
  input  logic              inLast,
  output logic              sclk,
  output logic              mosi,
  output logic              csN
);
  localparam int GC_W = $clog2(GROUP + 1);

  dpCtl_t          ctl;
  logic [GC_W-1:0] wordCnt;
  logic            lastBit;

  spi9_control #(
    .GROUP(GROUP), .HALF_DIV(HALF_DIV), .NATIVE_OK(NATIVE_OK)
  ) uCtl (
    .clk(clk), .rstN(rstN), .forceEmu(forceEmu), .inValid(inValid),
    .inLast(inLast), .wordCnt(wordCnt), .lastBit(lastBit),
    .inReady(inReady), .sclk(sclk), .csN(csN), .ctl(ctl)
  );

  spi9_datapath #(
    .DATA_W(DATA_W), .GROUP(GROUP)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .inDc(inDc),
    .wordCnt(wordCnt), .lastBit(lastBit), .mosi(mosi)
  );

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(mosi));
endmodule

// File: tb/sim_nine_bit_spi_tx.sv
module sim_nine_bit_spi_tx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic forceEmu = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inDc = 1'b0;
  logic inLast = 1'b0;
  logic inReady, sclk, mosi, csN;

  int total = 0;
  int bad = 0;
  bit expQ[$];
  bit benchEmu = 1'b0;
  int txnBits = 0;
  int groupPos = 0;
  int expLen[$];
  int seenBits = 0;
  int csRises = 0;
  int busyViol = 0;
  bit done = 1'b0;
  string reqTag = "R2";

  always #10 clk = ~clk;

  nine_bit_spi_tx u0 (
    .clk(clk), .rstN(rstN), .forceEmu(forceEmu), .inValid(inValid),
    .inReady(inReady), .inData(inData), .inDc(inDc), .inLast(inLast),
    .sclk(sclk), .mosi(mosi), .csN(csN)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: pushes the expected bit stream, then hands the byte over.
  task automatic sendWord(input logic dc, input logic [7:0] d, input logic last);
    expQ.push_back(dc);
    for (int i = 7; i >= 0; i--) expQ.push_back(d[i]);
    txnBits += 9;
    if (last) begin
      if (benchEmu) begin
        while (txnBits % 8 != 0) begin
          expQ.push_back(1'b0);
          txnBits++;
        end
      end
      expLen.push_back(txnBits);
      txnBits = 0;
    end
    @(negedge clk);
    inValid = 1'b1; inDc = dc; inData = d; inLast = last;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    groupPos = (groupPos + 1) % 8;
    if (benchEmu && !last && groupPos != 0)
      check("R5 ready while collecting", inReady, 1);
    if (!benchEmu)
      check("R9 busy after native accept", inReady, 0);
    if (last) groupPos = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while ((!csN || expQ.size() != 0 || !inReady) && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops one expected bit at every rising sclk.
  logic prevSclk = 1'b0;
  logic prevCs = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      if (sclk && inReady) busyViol++;
      if (sclk && !prevSclk) begin
        seenBits++;
        if (csN) check("R7 cs low at bit", csN, 0);
        if (expQ.size() == 0) begin
          check({reqTag, " unexpected bit"}, 1, 0);
        end else begin
          check({reqTag, " bit value"}, mosi, expQ.pop_front());
        end
      end
      if (csN && !prevCs) begin
        csRises++;
        check("R7 queue drained at cs rise", expQ.size(), 0);
        if (expLen.size() != 0)
          check({reqTag, " bits in transaction"}, seenBits, expLen.pop_front());
        seenBits = 0;
      end
    end
    prevSclk = sclk;
    prevCs = csN;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 csN", csN, 1);
    check("R1 sclk", sclk, 0);
    check("R1 mosi", mosi, 0);
    check("R1 inReady", inReady, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R4: single native command word
    reqTag = "R4"; benchEmu = 0;
    sendWord(1'b0, 8'hA5, 1'b1);
    waitIdle();
    check("R7 one cs rise", csRises, 1);

    // R2: native three-word transaction, cs held low between words
    reqTag = "R2";
    sendWord(1'b0, 8'h2A, 1'b0);
    sendWord(1'b1, 8'h00, 1'b0);
    sendWord(1'b1, 8'hFF, 1'b1);
    waitIdle();
    check("R7 cs held across words", csRises, 2);

    // R6: emulation, 3 words padded to 32 bits
    reqTag = "R6"; forceEmu = 1; benchEmu = 1;
    sendWord(1'b0, 8'h11, 1'b0);
    sendWord(1'b1, 8'h83, 1'b0);
    sendWord(1'b1, 8'h40, 1'b1);
    waitIdle();
    check("R6 cs rise count", csRises, 3);

    // R5: emulation, exactly 8 words -> 72 bits
    reqTag = "R5";
    for (int i = 0; i < 8; i++)
      sendWord(i[0], 8'(8'h3C + i * 17), i == 7);
    waitIdle();

    // R5 / R6: emulation, 10 words -> 72 + 24 bits
    reqTag = "R6";
    for (int i = 0; i < 10; i++)
      sendWord(~i[0], 8'(8'hC9 ^ i * 29), i == 9);
    waitIdle();
    check("R7 cs rise count emu", csRises, 5);

    // R8: native mode latched, forceEmu raised mid-transaction
    reqTag = "R8"; forceEmu = 0; benchEmu = 0;
    sendWord(1'b0, 8'h36, 1'b0);
    forceEmu = 1;
    sendWord(1'b1, 8'h68, 1'b1);
    waitIdle();
    forceEmu = 0;

    // R8: emulation latched, forceEmu dropped mid-transaction
    forceEmu = 1; benchEmu = 1;
    sendWord(1'b0, 8'h26, 1'b0);
    forceEmu = 0;
    sendWord(1'b1, 8'h01, 1'b1);
    waitIdle();
    check("R8 cs rise count", csRises, 7);

    check("R9 inReady low while sclk high", busyViol, 0);
    check("R3 sclk idle after run", sclk, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule